// File: doc/BRIEF.md
# Video FIFO Read Sequencer

This block empties a picture held in an external video FIFO memory. It drives that memory's active-low read-pointer reset, its active-low output enable and its read clock. It turns each byte request into one read-clock cycle, and each cycle into one byte on a stream output. The pin waveforms are generated from the system clock. Every phase of a waveform lasts a parameterized number of system cycles, so the slow memory sees clean, wide pulses. The default is about 1 µs at 100 MHz.

A start command rewinds the memory's read pointer. Byte requests are then honoured one at a time, and each completed read gives a one-cycle valid pulse with the byte. The byte is built from two 4-bit fields of a wider input port, because the memory's data lines land on two separate groups of port bits. A stop command switches the memory's outputs off and clocks out one more byte that is thrown away. Counting bytes per frame and the capture side are left to other logic.

Top module: `fifo_drain_seq`

## Requirements
- R1: After reset, read reset, output enable and read clock are all high, and byte-valid is low.
- R2: A start accepted in idle drops read reset and output enable in the same cycle. Both stay low while the read clock goes low, then high. After that read reset returns high and output enable stays low.
- R3: Each phase of the start, read and stop waveforms lasts exactly WAIT_CYC system clock cycles. With an accepted strobe sampled at edge e, the phases change at edges e+WAIT_CYC and e+2·WAIT_CYC. For start they also change at e+3·WAIT_CYC.
- R4: An accepted byte request puts the read clock high for WAIT_CYC cycles. The port is sampled at the end of that high phase, and the read clock drops in the same cycle that byte-valid rises. The read clock then stays low for WAIT_CYC cycles before another request can be taken.
- R5: The output byte places port bits 26:23 in its bits 7:4 and port bits 18:15 in its bits 3:0 (defaults HI_LSB=23, LO_LSB=15).
- R6: Byte-valid is high for exactly one cycle per accepted byte request.
- R7: A byte request does nothing unless a start has completed and no stop has followed. This holds in idle, during the start waveform and after a stop: no read-clock activity and no byte-valid.
- R8: A byte request that arrives while a byte read is in progress is dropped.
- R9: A stop accepted in the active state raises output enable at once. It then runs one read-clock cycle (high, then low, WAIT_CYC cycles each) with no byte-valid, and returns to idle with the read clock high. Stop wins over a byte request in the same cycle.
- R10: A start is taken only in idle, and a stop only in the active state. Otherwise they leave every output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe: rewind the memory's read pointer and enable reading |
| stop_i | input | 1 | Stop strobe: disable memory outputs after a dummy read |
| req_i | input | 1 | Byte request strobe |
| port_i | input | DATA_W | Wide input port carrying the memory's data nibbles |
| byte_o | output | 8 | Assembled byte |
| valid_o | output | 1 | One-cycle pulse with each assembled byte |
| fifo_rrst_n_o | output | 1 | Active-low read-pointer reset to the memory |
| fifo_oe_n_o | output | 1 | Active-low output enable to the memory |
| fifo_rclk_o | output | 1 | Read clock to the memory |

## Verification
The bench builds the block with WAIT_CYC=4, a 32-bit port and the default nibble positions. With the short phase it can probe every phase edge of the start, read and stop waveforms at its first and last cycle, within a few dozen clocks. It can also land stray requests and commands inside phases that are still running. The default nibble positions let bit patterns that set only one field, or everything except the fields, show that each output nibble comes from the right port bits.

// File: rtl/fds_pkg.sv
package fds_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RW_A,     // rewind: reset and enable low, clock high
    ST_RW_B,     // rewind: clock low
    ST_RW_C,     // rewind: clock high again
    ST_ACTIVE,
    ST_RD_HI,
    ST_RD_LO,
    ST_STOP_HI,
    ST_STOP_LO
  } seq_state_t;
endpackage

// File: rtl/fds_phase_timer.sv
module fds_phase_timer #(
  parameter int WAIT_CYC = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  output logic tick_o
);
  localparam int CW = $clog2(WAIT_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(WAIT_CYC - 1);

  logic [CW-1:0] cnt_q;

  // Counts from zero after each clear, then holds at the last value.
  always_ff @(posedge clk) begin
    if (rst || clr_i) cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);
  p_clr_restart_r3: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/fds_nibble_pack.sv
module fds_nibble_pack #(
  parameter int DATA_W = 32,
  parameter int HI_LSB = 23,
  parameter int LO_LSB = 15
) (
  input  logic [DATA_W-1:0] port_i,
  output logic [7:0]        byte_o
);
  localparam int NIB = 4;
  localparam int NUM = 2;

  function automatic int field_lsb(int idx);
    return (idx == 1) ? HI_LSB : LO_LSB;
  endfunction

  for (genvar g = 0; g < NUM; g++) begin : g_nib
    assign byte_o[g*NIB +: NIB] = port_i[field_lsb(g) +: NIB];
  end
endmodule

// File: rtl/fds_seq_fsm.sv
module fds_seq_fsm
  import fds_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       req_i,
  input  logic       tick_i,
  input  logic [7:0] packed_i,
  output logic       clr_o,
  output logic [7:0] byte_o,
  output logic       valid_o,
  output logic       rrst_n_o,
  output logic       oe_n_o,
  output logic       rclk_o
);
  seq_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (start_i) state_d = ST_RW_A;
      ST_RW_A:    if (tick_i) state_d = ST_RW_B;
      ST_RW_B:    if (tick_i) state_d = ST_RW_C;
      ST_RW_C:    if (tick_i) state_d = ST_ACTIVE;
      ST_ACTIVE:  if (stop_i) state_d = ST_STOP_HI;
                  else if (req_i) state_d = ST_RD_HI;
      ST_RD_HI:   if (tick_i) state_d = ST_RD_LO;
      ST_RD_LO:   if (tick_i) state_d = ST_ACTIVE;
      ST_STOP_HI: if (tick_i) state_d = ST_STOP_LO;
      ST_STOP_LO: if (tick_i) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  assign clr_o = (state_d != state_q);

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  // Pins are registered from the next state so they change with it.
  always_ff @(posedge clk) begin
    if (rst) begin
      rrst_n_o <= 1'b1;
      oe_n_o   <= 1'b1;
      rclk_o   <= 1'b1;
    end else begin
      rrst_n_o <= !(state_d inside {ST_RW_A, ST_RW_B, ST_RW_C});
      oe_n_o   <= !(state_d inside {ST_RW_A, ST_RW_B, ST_RW_C,
                                    ST_ACTIVE, ST_RD_HI, ST_RD_LO});
      if (state_d inside {ST_RW_B, ST_RD_LO, ST_STOP_LO}) rclk_o <= 1'b0;
      else if (state_d != ST_ACTIVE)                       rclk_o <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      byte_o  <= '0;
    end else begin
      valid_o <= (state_q == ST_RD_HI) && tick_i;
      if ((state_q == ST_RD_HI) && tick_i) byte_o <= packed_i;
    end
  end

  p_oe_with_rrst_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(rrst_n_o) |-> $fell(oe_n_o));
  p_rrst_rise_enabled_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(rrst_n_o) |-> !oe_n_o && rclk_o);
  p_valid_on_fall_r4: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> !rclk_o && $past(rclk_o));
  p_valid_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);
  p_no_valid_disabled_r7: assert property (@(posedge clk) disable iff (rst)
    oe_n_o |-> !valid_o);
  p_stop_oe_rise_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(oe_n_o) |-> rrst_n_o && rclk_o);
endmodule

// File: rtl/fifo_drain_seq.sv
module fifo_drain_seq #(
  parameter int DATA_W   = 32,
  parameter int HI_LSB   = 23,
  parameter int LO_LSB   = 15,
  parameter int WAIT_CYC = 100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              req_i,
  input  logic [DATA_W-1:0] port_i,
  output logic [7:0]        byte_o,
  output logic              valid_o,
  output logic              fifo_rrst_n_o,
  output logic              fifo_oe_n_o,
  output logic              fifo_rclk_o
);
  logic       clr;
  logic       tick;
  logic [7:0] packed_byte;

  fds_phase_timer #(.WAIT_CYC(WAIT_CYC)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (clr),
    .tick_o (tick)
  );

  fds_nibble_pack #(.DATA_W(DATA_W), .HI_LSB(HI_LSB), .LO_LSB(LO_LSB)) u_pack (
    .port_i (port_i),
    .byte_o (packed_byte)
  );

  fds_seq_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .stop_i   (stop_i),
    .req_i    (req_i),
    .tick_i   (tick),
    .packed_i (packed_byte),
    .clr_o    (clr),
    .byte_o   (byte_o),
    .valid_o  (valid_o),
    .rrst_n_o (fifo_rrst_n_o),
    .oe_n_o   (fifo_oe_n_o),
    .rclk_o   (fifo_rclk_o)
  );
endmodule

// File: tb/tb_fifo_drain_seq.sv
module tb_fifo_drain_seq;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 4;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0, stop_i = 1'b0, req_i = 1'b0;
  logic [DW-1:0] port_i = '0;
  logic [7:0] byte_o;
  logic valid_o, rrst_n, oe_n, rclk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [7:0] sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  fifo_drain_seq #(.DATA_W(DW), .WAIT_CYC(W)) dut (
    .clk(clk), .rst(rst), .start_i(start_i), .stop_i(stop_i), .req_i(req_i),
    .port_i(port_i), .byte_o(byte_o), .valid_o(valid_o),
    .fifo_rrst_n_o(rrst_n), .fifo_oe_n_o(oe_n), .fifo_rclk_o(rclk)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic pins(string tag, bit r, bit o, bit c);
    check({tag, " rrst_n"}, int'(rrst_n), int'(r));
    check({tag, " oe_n"},   int'(oe_n),   int'(o));
    check({tag, " rclk"},   int'(rclk),   int'(c));
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  // Scoreboard monitor: every valid byte must match the oldest expectation.
  always @(negedge clk) begin
    if (!rst && valid_o) begin
      checks++;
      if (sb_q.size() == 0) begin
        fails++;
        $display("FAIL R7/R8 unexpected byte: actual %0h expected none", byte_o);
      end else begin
        logic [7:0] e;
        e = sb_q.pop_front();
        if (byte_o !== e) begin
          fails++;
          $display("FAIL R5 byte: actual %0h expected %0h", byte_o, e);
        end
      end
    end
  end

  // Driver: one accepted read with R4/R6 timing checks.
  task automatic read_byte(logic [DW-1:0] v);
    port_i = v;
    sb_q.push_back({v[26:23], v[18:15]});
    req_i = 1'b1; step(1); req_i = 1'b0;              // k=0
    check("R4 rclk high k0", int'(rclk), 1);
    step(W-1);                                        // k=W-1
    check("R4 rclk high end", int'(rclk), 1);
    check("R6 no early valid", int'(valid_o), 0);
    step(1);                                          // k=W
    check("R4 rclk falls", int'(rclk), 0);
    check("R4 valid with fall", int'(valid_o), 1);
    step(1);
    check("R6 valid one cycle", int'(valid_o), 0);
    step(W-1);                                        // k=2W, active
    check("R4 rclk stays low", int'(rclk), 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    pins("R1 reset", 1, 1, 1);
    check("R1 valid", int'(valid_o), 0);

    // R7: request in idle
    req_i = 1'b1; step(1); req_i = 1'b0;
    step(2 * W);
    pins("R7 idle req", 1, 1, 1);

    // R10: stop in idle
    stop_i = 1'b1; step(1); stop_i = 1'b0;
    step(W);
    pins("R10 idle stop", 1, 1, 1);

    // R2/R3: start waveform, with a stray request inside it (R7)
    start_i = 1'b1; step(1); start_i = 1'b0;          // k=0
    pins("R2 rewind A", 0, 0, 1);
    req_i = 1'b1; step(1); req_i = 1'b0;              // k=1
    step(W-2);                                        // k=W-1
    pins("R3 rewind A end", 0, 0, 1);
    step(1);                                          // k=W
    pins("R2 rewind B", 0, 0, 0);
    step(W-1);
    pins("R3 rewind B end", 0, 0, 0);
    step(1);                                          // k=2W
    pins("R2 rewind C", 0, 0, 1);
    step(W-1);
    pins("R3 rewind C end", 0, 0, 1);
    step(1);                                          // k=3W
    pins("R2 active", 1, 0, 1);

    // R10: start while active
    start_i = 1'b1; step(1); start_i = 1'b0;
    step(W);
    pins("R10 active start", 1, 0, 1);

    // R4/R5/R6: reads with distinct patterns
    read_byte(32'h0787_8000);   // both fields all ones -> FF
    read_byte(32'hF878_7FFF);   // everything but fields -> 00
    read_byte(32'h0380_0000);   // upper field 0111 -> 70
    read_byte(32'h0004_8000);   // lower field 1001 -> 09
    read_byte(32'h5A5A_A5A5);

    // R8: second request during the high phase is dropped
    port_i = 32'h0500_8000;
    sb_q.push_back(8'hA1);
    req_i = 1'b1; step(1); req_i = 1'b0;              // k=0
    req_i = 1'b1; step(1); req_i = 1'b0;              // sampled in read
    step(3 * W);
    check("R8 single byte", sb_q.size(), 0);
    check("R8 rclk idle low", int'(rclk), 0);

    // R9: stop together with request; stop wins
    stop_i = 1'b1; req_i = 1'b1; step(1); stop_i = 1'b0; req_i = 1'b0;
    pins("R9 stop high", 1, 1, 1);
    step(W-1);
    pins("R9 stop high end", 1, 1, 1);
    step(1);
    pins("R9 dummy low", 1, 1, 0);
    check("R9 no valid", int'(valid_o), 0);
    step(W);
    pins("R9 idle", 1, 1, 1);

    // R7: request after stop
    req_i = 1'b1; step(1); req_i = 1'b0;
    step(2 * W);
    pins("R7 post-stop req", 1, 1, 1);
    check("R5 queue drained", sb_q.size(), 0);

    finish_run();
  end
endmodule